// File: doc/BRIEF.md
# APB Peripheral Register File

This block sits between an APB bus master and a peripheral core. It holds the core's control values, presents the core's status values to software, and turns selected bus writes into one-cycle command pulses. Each register lives at a fixed word offset and has one of three access styles. A stored register drives core pins and reads back what was last written. A status register shows a live core value and ignores writes. A split register reads one core pin and writes a separate stored register that drives a different core pin.

A group of external pins reaches the core through a two-stage synchronizer clocked by the bus clock. The reset input's active level is chosen by a parameter. The bus side never stalls and never signals an error. APB is the only interface, so there is no stream handshake and back-pressure does not apply. The core pins are plain levels.

Top module: `periph_csr_apb`

## Requirements
- R1: While reset is active, and on leaving it, every stored output (core_dout, core_cfg, core_tmr_en, core_cnt_en, core_go, core_ext_sync) is zero.
- R2: The stored config register at byte offset 0x4 takes pwdata[CFG_W-1:0] on an access-phase write, drives core_cfg from the next cycle, and a bus read of 0x4 returns the last value written.
- R3: A read of byte offset 0x8 returns the live core_capture value, zero-extended. A write to 0x8 changes no output and no readback.
- R4: At byte offset 0x0, a write stores pwdata[DIO_W-1:0] onto core_dout, while a read returns core_din and not the written value.
- R5: At byte offset 0xC, bit 0 is the timer enable (core_tmr_en) and bit 1 is the counter enable (core_cnt_en). Both are stored levels, and a read returns them in those bit positions.
- R6: Bit 2 of offset 0xC self-clears. Writing 1 raises core_go for exactly one cycle after the write, and it then reads back as 0.
- R7: A write commits only when psel, penable and pwrite are all high. A setup phase alone changes nothing.
- R8: Reads of any word index above 3 (byte offset 0x10 and up) return zero, and writes there change nothing.
- R9: pready is always 1 and pslverr is always 0.
- R10: ext_in reaches core_ext_sync after exactly two rising clock edges.
- R11: With RST_LEVEL = 0, rst_in is active-low. With RST_LEVEL = 1, it is active-high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and core clock |
| rst_in | input | 1 | Asynchronous reset, polarity set by RST_LEVEL |
| paddr | input | AW | Byte address; bits [AW-1:2] select the word |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| pwdata | input | DW | Write data |
| prdata | output | DW | Read data, valid while psel is high |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| core_din | input | DIO_W | Core value read at offset 0x0 |
| core_dout | output | DIO_W | Stored value written at offset 0x0 |
| core_cfg | output | CFG_W | Stored config from offset 0x4 |
| core_capture | input | CAP_W | Core status read at offset 0x8 |
| core_tmr_en | output | 1 | Timer enable level |
| core_cnt_en | output | 1 | Counter enable level |
| core_go | output | 1 | One-cycle command pulse |
| ext_in | input | SYNC_W | Asynchronous external pins |
| core_ext_sync | output | SYNC_W | ext_in after two flops |

## Verification
Stored outputs change on the rising edge that closes the access phase. Each write task therefore returns on the falling edge after that edge, where the new value and the core_go pulse are visible. One more falling edge later, core_go must be low again. Read data is combinational, so each read samples prdata one nanosecond into the access phase. Synchronized pins are checked on the falling edge after the first rising edge, where the old value must still be present, and again after the second, where the new value must appear.

// File: rtl/periph_csr_pkg.sv
package periph_csr_pkg;
  // Word indices (byte offset / 4); software depends on these
  localparam int unsigned WIDX_DATA = 0;
  localparam int unsigned WIDX_CFG  = 1;
  localparam int unsigned WIDX_CAP  = 2;
  localparam int unsigned WIDX_CTRL = 3;
  localparam int unsigned WIDX_LAST = WIDX_CTRL;

  // Control register bit positions
  localparam int unsigned CTRL_W = 3;
  localparam int unsigned CB_TMR = 0;
  localparam int unsigned CB_CNT = 1;
  localparam int unsigned CB_GO  = 2;
  localparam logic [CTRL_W-1:0] CTRL_AC_MASK = 3'b100;
endpackage

// File: rtl/csr_sync2.sv
module csr_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/csr_field.sv
module csr_field #(
  parameter int           W       = 8,
  parameter logic [W-1:0] AC_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    if (AC_MASK[i]) begin : g_pulse
      // self-clearing: high only for the cycle after a write of 1
      always_ff @(posedge clk or posedge rst) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= we & d[i];
      end
    end else begin : g_hold
      always_ff @(posedge clk or posedge rst) begin
        if (rst)     bit_q <= 1'b0;
        else if (we) bit_q <= d[i];
      end
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/periph_csr_apb.sv
module periph_csr_apb
  import periph_csr_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int CFG_W     = 8,
  parameter int CAP_W     = 16,
  parameter int DIO_W     = 8,
  parameter int SYNC_W    = 4,
  parameter bit RST_LEVEL = 1'b0
) (
  input  logic              pclk,
  input  logic              rst_in,
  input  logic [AW-1:0]     paddr,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [DIO_W-1:0]  core_din,
  output logic [DIO_W-1:0]  core_dout,
  output logic [CFG_W-1:0]  core_cfg,
  input  logic [CAP_W-1:0]  core_capture,
  output logic              core_tmr_en,
  output logic              core_cnt_en,
  output logic              core_go,
  input  logic [SYNC_W-1:0] ext_in,
  output logic [SYNC_W-1:0] core_ext_sync
);
  localparam int IDX_W = AW - 2;

  logic              rst_act;
  logic [IDX_W-1:0]  widx;
  logic              wr_acc;
  logic              hit_data, hit_cfg, hit_ctrl;
  logic [CTRL_W-1:0] ctrl_q;
  logic              unused_bits;

  assign rst_act = RST_LEVEL ? rst_in : ~rst_in;
  assign widx    = paddr[AW-1:2];
  assign wr_acc  = psel & penable & pwrite;

  assign hit_data = (widx == IDX_W'(WIDX_DATA));
  assign hit_cfg  = (widx == IDX_W'(WIDX_CFG));
  assign hit_ctrl = (widx == IDX_W'(WIDX_CTRL));

  csr_field #(.W(DIO_W), .AC_MASK('0)) u_data (
    .clk(pclk), .rst(rst_act), .we(wr_acc & hit_data),
    .d(pwdata[DIO_W-1:0]), .q(core_dout)
  );

  csr_field #(.W(CFG_W), .AC_MASK('0)) u_cfg (
    .clk(pclk), .rst(rst_act), .we(wr_acc & hit_cfg),
    .d(pwdata[CFG_W-1:0]), .q(core_cfg)
  );

  csr_field #(.W(CTRL_W), .AC_MASK(CTRL_AC_MASK)) u_ctrl (
    .clk(pclk), .rst(rst_act), .we(wr_acc & hit_ctrl),
    .d(pwdata[CTRL_W-1:0]), .q(ctrl_q)
  );

  assign core_tmr_en = ctrl_q[CB_TMR];
  assign core_cnt_en = ctrl_q[CB_CNT];
  assign core_go     = ctrl_q[CB_GO];

  csr_sync2 #(.W(SYNC_W)) u_sync (
    .clk(pclk), .rst(rst_act), .d(ext_in), .q(core_ext_sync)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      unique case (widx)
        IDX_W'(WIDX_DATA): prdata[DIO_W-1:0]  = core_din;
        IDX_W'(WIDX_CFG):  prdata[CFG_W-1:0]  = core_cfg;
        IDX_W'(WIDX_CAP):  prdata[CAP_W-1:0]  = core_capture;
        IDX_W'(WIDX_CTRL): prdata[CTRL_W-1:0] = ctrl_q;
        default:           prdata = '0;
      endcase
    end
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign unused_bits = ^pwdata ^ ^paddr[1:0];
endmodule

// File: rtl/periph_csr_chk.sv
module periph_csr_chk
  import periph_csr_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int CFG_W     = 8,
  parameter int CAP_W     = 16,
  parameter int DIO_W     = 8,
  parameter int SYNC_W    = 4,
  parameter bit RST_LEVEL = 1'b0
) (
  input logic              pclk,
  input logic              rst_in,
  input logic [AW-3:0]     widx,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic              wr_go_bit,
  input logic [DW-1:0]     prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [DIO_W-1:0]  core_dout,
  input logic [CFG_W-1:0]  core_cfg,
  input logic [CAP_W-1:0]  core_capture,
  input logic              core_go,
  input logic [SYNC_W-1:0] ext_in,
  input logic [SYNC_W-1:0] core_ext_sync
);
  logic       rst_act;
  logic [1:0] since_rst;

  assign rst_act = RST_LEVEL ? rst_in : ~rst_in;

  always_ff @(posedge pclk or posedge rst_act) begin
    if (rst_act)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_bus_ok_R9: assert property (@(posedge pclk) disable iff (rst_act)
    pready && !pslverr);

  assert_cfg_hold_R2: assert property (@(posedge pclk) disable iff (rst_act)
    !(psel && penable && pwrite) |=> $stable(core_cfg));

  assert_setup_inert_R7: assert property (@(posedge pclk) disable iff (rst_act)
    (psel && !penable) |=> $stable(core_dout));

  assert_go_single_R6: assert property (@(posedge pclk) disable iff (rst_act)
    core_go |=> !core_go);

  assert_go_cause_R6: assert property (@(posedge pclk) disable iff (rst_act)
    $rose(core_go) |-> $past(psel && penable && pwrite && wr_go_bit &&
                             (widx == (AW-2)'(WIDX_CTRL))));

  assert_unmapped_zero_R8: assert property (@(posedge pclk) disable iff (rst_act)
    (psel && widx > (AW-2)'(WIDX_LAST)) |-> (prdata == '0));

  assert_cap_live_R3: assert property (@(posedge pclk) disable iff (rst_act)
    (psel && !pwrite && widx == (AW-2)'(WIDX_CAP)) |-> (prdata == DW'(core_capture)));

  assert_sync_delay_R10: assert property (@(posedge pclk) disable iff (rst_act)
    (since_rst >= 2'd2) |-> (core_ext_sync == $past(ext_in, 2)));
endmodule

bind periph_csr_apb periph_csr_chk #(
  .AW(AW), .DW(DW), .CFG_W(CFG_W), .CAP_W(CAP_W), .DIO_W(DIO_W),
  .SYNC_W(SYNC_W), .RST_LEVEL(RST_LEVEL)
) u_chk (
  .pclk(pclk), .rst_in(rst_in), .widx(paddr[AW-1:2]), .psel(psel),
  .penable(penable), .pwrite(pwrite), .wr_go_bit(pwdata[periph_csr_pkg::CB_GO]),
  .prdata(prdata), .pready(pready), .pslverr(pslverr), .core_dout(core_dout),
  .core_cfg(core_cfg), .core_capture(core_capture), .core_go(core_go),
  .ext_in(ext_in), .core_ext_sync(core_ext_sync)
);

// File: tb/tb_periph_csr_apb.sv
module tb_periph_csr_apb;
  logic        pclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_hi = 1'b1;
  logic [7:0]  paddr = '0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] pwdata = '0;
  logic [7:0]  core_din = '0;
  logic [15:0] core_capture = '0;
  logic [3:0]  ext_in = '0;

  logic [31:0] prdata, prdata_h;
  logic        pready, pslverr, pready_h, pslverr_h;
  logic [7:0]  core_dout, core_cfg, dout_h, cfg_h;
  logic        tmr, cnt, go, tmr_h, cnt_h, go_h;
  logic [3:0]  ext_sync, ext_sync_h;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 pclk = ~pclk;

  periph_csr_apb dut (
    .pclk(pclk), .rst_in(rst_n), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .core_din(core_din), .core_dout(core_dout),
    .core_cfg(core_cfg), .core_capture(core_capture), .core_tmr_en(tmr),
    .core_cnt_en(cnt), .core_go(go), .ext_in(ext_in), .core_ext_sync(ext_sync)
  );

  periph_csr_apb #(.RST_LEVEL(1'b1)) dut_hi (
    .pclk(pclk), .rst_in(rst_hi), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata_h), .pready(pready_h),
    .pslverr(pslverr_h), .core_din(core_din), .core_dout(dout_h),
    .core_cfg(cfg_h), .core_capture(core_capture), .core_tmr_en(tmr_h),
    .core_cnt_en(cnt_h), .core_go(go_h), .ext_in(ext_in), .core_ext_sync(ext_sync_h)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1;
    #1 d = prdata;
    chk("R9", "pready/pslverr during read", {30'd0, pready, pslverr}, 32'd2);
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic t_reset();
    chk("R1", "dout in reset", {24'd0, core_dout}, 0);
    chk("R1", "cfg in reset", {24'd0, core_cfg}, 0);
    chk("R1", "ctrl pins in reset", {29'd0, tmr, cnt, go}, 0);
    chk("R11", "high-level reset holds cfg", {24'd0, cfg_h}, 0);
    @(negedge pclk); rst_n = 1; rst_hi = 0;
    @(negedge pclk);
    chk("R1", "sync out after reset", {28'd0, ext_sync}, 0);
    chk("R9", "pready/pslverr idle", {30'd0, pready, pslverr}, 32'd2);
  endtask

  task automatic t_cfg();
    logic [31:0] r;
    apb_write(8'h04, 32'hFFFF_FFA5);
    chk("R2", "core_cfg after write", {24'd0, core_cfg}, 32'hA5);
    chk("R11", "active-high instance left reset", {24'd0, cfg_h}, 32'hA5);
    apb_read(8'h04, r);
    chk("R2", "cfg readback", r, 32'hA5);
    apb_write(8'h04, 32'h3C);
    apb_read(8'h04, r);
    chk("R2", "cfg readback 2", r, 32'h3C);
  endtask

  task automatic t_cap();
    logic [31:0] r;
    core_capture = 16'h1234;
    apb_read(8'h08, r);
    chk("R3", "capture read", r, 32'h1234);
    core_capture = 16'hBEEF;
    apb_read(8'h08, r);
    chk("R3", "capture live", r, 32'hBEEF);
    apb_write(8'h08, 32'hFFFF_FFFF);
    chk("R3", "write to capture leaves cfg", {24'd0, core_cfg}, 32'h3C);
    chk("R3", "write to capture leaves dout/ctrl", {21'd0, core_dout, tmr, cnt, go}, 0);
    apb_read(8'h08, r);
    chk("R3", "capture after write", r, 32'hBEEF);
  endtask

  task automatic t_split();
    logic [31:0] r;
    core_din = 8'h5A;
    apb_write(8'h00, 32'hC3);
    chk("R4", "core_dout after write", {24'd0, core_dout}, 32'hC3);
    apb_read(8'h00, r);
    chk("R4", "read returns core_din", r, 32'h5A);
  endtask

  task automatic t_ctrl();
    logic [31:0] r;
    apb_write(8'h0C, 32'h1);
    chk("R5", "tmr only", {30'd0, tmr, cnt}, 32'h2);
    apb_write(8'h0C, 32'h2);
    chk("R5", "cnt only", {30'd0, tmr, cnt}, 32'h1);
    apb_write(8'h0C, 32'h3);
    apb_read(8'h0C, r);
    chk("R5", "ctrl readback", r, 32'h3);
  endtask

  task automatic t_go();
    logic [31:0] r;
    apb_write(8'h0C, 32'h7);
    chk("R6", "go pulse high", {31'd0, go}, 1);
    chk("R6", "levels with go", {30'd0, tmr, cnt}, 3);
    @(negedge pclk);
    chk("R6", "go cleared next cycle", {31'd0, go}, 0);
    apb_read(8'h0C, r);
    chk("R6", "go reads back zero", r, 32'h3);
  endtask

  task automatic t_setup_only();
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = 8'h04; pwdata = 32'h11;
    @(negedge pclk); psel = 0; pwrite = 0;
    @(negedge pclk);
    chk("R7", "setup phase alone", {24'd0, core_cfg}, 32'h3C);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    apb_read(8'h10, r);
    chk("R8", "read 0x10", r, 0);
    apb_read(8'hFC, r);
    chk("R8", "read 0xFC", r, 0);
    apb_write(8'h14, 32'hFFFF_FFFF);
    chk("R8", "unmapped write leaves outputs",
        {core_dout, core_cfg, 5'd0, tmr, cnt, go}, {8'hC3, 8'h3C, 8'h06});
  endtask

  task automatic t_sync();
    @(negedge pclk); ext_in = 4'h9;
    @(negedge pclk);
    chk("R10", "after one edge still old", {28'd0, ext_sync}, 0);
    @(negedge pclk);
    chk("R10", "after two edges new", {28'd0, ext_sync}, 32'h9);
    ext_in = 4'h6;
    @(negedge pclk);
    @(negedge pclk);
    chk("R10", "second value", {28'd0, ext_sync}, 32'h6);
  endtask

  initial begin
    #5;
    t_reset();
    t_cfg();
    t_cap();
    t_split();
    t_ctrl();
    t_go();
    t_setup_only();
    t_unmapped();
    t_sync();
    done = 1'b1;
    summary();
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end
endmodule